// File: doc/BRIEF.md
# Exception Entry Controller

This block performs exception entry and return for a small 32-bit RISC core. Each cycle it looks at six cause request lines and at the external interrupt lines. When a cause is accepted it does three things in that same cycle. It asserts a redirect strobe with the handler address. It asserts a write enable for one of two link registers, carrying the current program counter. It then updates the interrupt-enable state on the next clock edge.

Causes fall into two classes. The debug class contains breakpoint and watchpoint. It saves the program counter to the breakpoint-address link and keeps the old global enable in a saved debug-enable bit. The other causes are instruction bus error, data bus error, divide by zero, interrupt and system call. They use the exception-address link and a saved exception-enable bit. The handler lies at a base address plus 32 bytes per cause code. A remap control picks either the normal base or the debug base for every cause.

The two return strobes restore the global enable from the matching saved bit. They also redirect fetch to the saved address, which the register file presents on the block's inputs. A direct write path lets the core's control-register logic load all three enable bits.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Cause codes are reset 0, breakpoint 1, instruction bus error 2, watchpoint 3, data bus error 4, divide by zero 5, interrupt 6, system call 7. When several causes are requested together, the lowest code is accepted. `exc_taken` is high and `exc_cause` shows the accepted code in that same cycle.
- R2: A non-debug cause (2, 4, 5, 6, 7) asserts `ea_we`, and not `ba_we`, in the cycle of acceptance. `link_pc` equals `cur_pc` and `redirect` is high in that same cycle.
- R3: After a non-debug cause is accepted, `eie` holds the value `gie` had before the edge, and `gie` is 0. `bie` does not change.
- R4: A debug cause (1, 3) asserts `ba_we`, and not `ea_we`, with `link_pc` equal to `cur_pc`. After the edge, `bie` holds the previous `gie`, `gie` is 0, and `eie` does not change.
- R5: On acceptance, `redirect_pc` equals the selected base plus the cause code times 32, modulo 2^32.
- R6: When `remap_en` is 1, `dbg_base` is the base for every cause. When it is 0, `exc_base` is the base for every cause.
- R7: An interrupt (cause 6) is accepted only while `gie` is 1 and some bit is set in both `irq_pending` and `irq_mask`.
- R8: `eret` with no accepted cause redirects to `ea_val` and loads `gie` from `eie`. `bret` with no accepted cause and no `eret` redirects to `ba_val` and loads `gie` from `bie`. The saved bits do not change.
- R9: Priority runs from accepted cause, to `eret`, to `bret`, to an enable write. A lower-priority action in the same cycle has no effect on the enable bits or on `redirect_pc`.
- R10: After reset, `gie`, `eie` and `bie` are 0, and `redirect` is low when no request is present.
- R11: `ie_wr` with no higher-priority action loads `ie_wdata[0]` into `gie`, `ie_wdata[1]` into `eie` and `ie_wdata[2]` into `bie`. It does not assert `redirect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | Program counter of the instruction being excepted |
| req_bkpt | input | 1 | Breakpoint request (cause 1) |
| req_ibus | input | 1 | Instruction bus error request (cause 2) |
| req_wpt | input | 1 | Watchpoint request (cause 3) |
| req_dbus | input | 1 | Data bus error request (cause 4) |
| req_div0 | input | 1 | Divide-by-zero request (cause 5) |
| req_scall | input | 1 | System call request (cause 7) |
| irq_pending | input | 32 | Pending external interrupt lines |
| irq_mask | input | 32 | Interrupt line mask, 1 = enabled |
| exc_base | input | 32 | Normal handler base |
| dbg_base | input | 32 | Debug handler base |
| remap_en | input | 1 | Use debug base for all causes |
| eret | input | 1 | Return from exception strobe |
| bret | input | 1 | Return from breakpoint strobe |
| ea_val | input | 32 | Current exception-address link value |
| ba_val | input | 32 | Current breakpoint-address link value |
| ie_wr | input | 1 | Enable-bit write strobe |
| ie_wdata | input | 3 | Enable write data {bie, eie, gie} |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_pc | output | 32 | Redirect target |
| exc_taken | output | 1 | A cause is accepted this cycle |
| exc_cause | output | 3 | Accepted cause code |
| ea_we | output | 1 | Write exception-address link |
| ba_we | output | 1 | Write breakpoint-address link |
| link_pc | output | 32 | Data for the link write |
| gie | output | 1 | Global interrupt enable |
| eie | output | 1 | Saved exception enable |
| bie | output | 1 | Saved debug enable |

## Verification
Two things can land in the same cycle. An accepted cause can meet a return strobe or an enable write. A debug-class cause can meet a non-debug cause, and the lower code must win. The bench sweeps every combination of the six request lines against three interrupt situations, all eight enable states and both remap settings. It computes the winner and the handler address arithmetically. Separate sweeps raise `eret`, `bret` and `ie_wr` together with and without a system call. They check that only the top-priority action moves the enable bits and the redirect target.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W  = 3;
  localparam int NUM_CAUSE = 1 << CAUSE_W;

  typedef enum logic [CAUSE_W-1:0] {
    CS_RESET = 3'd0,
    CS_BKPT  = 3'd1,
    CS_IBUS  = 3'd2,
    CS_WPT   = 3'd3,
    CS_DBUS  = 3'd4,
    CS_DIV0  = 3'd5,
    CS_IRQ   = 3'd6,
    CS_SCALL = 3'd7
  } cause_e;

  function automatic logic is_debug(input logic [CAUSE_W-1:0] c);
    return (c == CS_BKPT) || (c == CS_WPT);
  endfunction
endpackage

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
#(
  parameter int N = NUM_CAUSE,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N:0]   lower_any;
  logic [N-1:0] grant;

  assign lower_any[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      assign grant[g]       = req[g] & ~lower_any[g];
      assign lower_any[g+1] = lower_any[g] | req[g];
    end
  endgenerate

  assign any = lower_any[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 3,
  parameter int VSHIFT  = 5,
  localparam int PADW   = XLEN - CAUSE_W - VSHIFT
) (
  input  logic [XLEN-1:0]    exc_base,
  input  logic [XLEN-1:0]    dbg_base,
  input  logic               remap_en,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    target
);
  logic [XLEN-1:0] base_sel;
  logic [XLEN-1:0] offset;

  assign base_sel = remap_en ? dbg_base : exc_base;
  assign offset   = {{PADW{1'b0}}, cause, {VSHIFT{1'b0}}};
  assign target   = base_sel + offset;
endmodule

// File: rtl/exc_ie_state.sv
module exc_ie_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_dbg,
  input  logic       do_eret,
  input  logic       do_bret,
  input  logic       do_wr,
  input  logic [2:0] wdata,
  output logic       gie,
  output logic       eie,
  output logic       bie
);
  logic gie_d, eie_d, bie_d;
  logic upd;

  always_comb begin
    gie_d = gie;
    eie_d = eie;
    bie_d = bie;
    if (take) begin
      gie_d = 1'b0;
      if (take_dbg) bie_d = gie;
      else          eie_d = gie;
    end else if (do_eret) begin
      gie_d = eie;
    end else if (do_bret) begin
      gie_d = bie;
    end else if (do_wr) begin
      gie_d = wdata[0];
      eie_d = wdata[1];
      bie_d = wdata[2];
    end
  end

  assign upd = take | do_eret | do_bret | do_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie <= 1'b0;
      eie <= 1'b0;
      bie <= 1'b0;
    end else if (upd) begin
      gie <= gie_d;
      eie <= eie_d;
      bie <= bie_d;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 32,
  parameter int VSHIFT  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               req_bkpt,
  input  logic               req_ibus,
  input  logic               req_wpt,
  input  logic               req_dbus,
  input  logic               req_div0,
  input  logic               req_scall,
  input  logic [NUM_IRQ-1:0] irq_pending,
  input  logic [NUM_IRQ-1:0] irq_mask,
  input  logic [XLEN-1:0]    exc_base,
  input  logic [XLEN-1:0]    dbg_base,
  input  logic               remap_en,
  input  logic               eret,
  input  logic               bret,
  input  logic [XLEN-1:0]    ea_val,
  input  logic [XLEN-1:0]    ba_val,
  input  logic               ie_wr,
  input  logic [2:0]         ie_wdata,
  output logic               redirect,
  output logic [XLEN-1:0]    redirect_pc,
  output logic               exc_taken,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic               ea_we,
  output logic               ba_we,
  output logic [XLEN-1:0]    link_pc,
  output logic               gie,
  output logic               eie,
  output logic               bie
);
  logic [NUM_CAUSE-1:0] req_vec;
  logic                 irq_ok;
  logic                 take_dbg;
  logic [XLEN-1:0]      vec_pc;
  logic                 do_eret, do_bret, do_wr;

  assign irq_ok = gie & (|(irq_pending & irq_mask));

  always_comb begin
    req_vec           = '0;
    req_vec[CS_BKPT]  = req_bkpt;
    req_vec[CS_IBUS]  = req_ibus;
    req_vec[CS_WPT]   = req_wpt;
    req_vec[CS_DBUS]  = req_dbus;
    req_vec[CS_DIV0]  = req_div0;
    req_vec[CS_IRQ]   = irq_ok;
    req_vec[CS_SCALL] = req_scall;
  end

  exc_prio #(.N(NUM_CAUSE)) u_prio (
    .req (req_vec),
    .any (exc_taken),
    .idx (exc_cause)
  );

  exc_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VSHIFT(VSHIFT)) u_vec (
    .exc_base (exc_base),
    .dbg_base (dbg_base),
    .remap_en (remap_en),
    .cause    (exc_cause),
    .target   (vec_pc)
  );

  assign take_dbg = is_debug(exc_cause);
  assign do_eret  = ~exc_taken & eret;
  assign do_bret  = ~exc_taken & ~eret & bret;
  assign do_wr    = ~exc_taken & ~eret & ~bret & ie_wr;

  exc_ie_state u_ie (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (exc_taken),
    .take_dbg (take_dbg),
    .do_eret  (do_eret),
    .do_bret  (do_bret),
    .do_wr    (do_wr),
    .wdata    (ie_wdata),
    .gie      (gie),
    .eie      (eie),
    .bie      (bie)
  );

  assign ea_we    = exc_taken & ~take_dbg;
  assign ba_we    = exc_taken &  take_dbg;
  assign link_pc  = cur_pc;
  assign redirect = exc_taken | eret | bret;

  always_comb begin
    if (exc_taken)    redirect_pc = vec_pc;
    else if (eret)    redirect_pc = ea_val;
    else              redirect_pc = ba_val;
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [XLEN-1:0]    cur_pc,
  input logic [NUM_IRQ-1:0] irq_pending,
  input logic [NUM_IRQ-1:0] irq_mask,
  input logic               req_bkpt,
  input logic               req_ibus,
  input logic               req_wpt,
  input logic               req_dbus,
  input logic               req_div0,
  input logic               req_scall,
  input logic               eret,
  input logic               redirect,
  input logic               exc_taken,
  input logic [2:0]         exc_cause,
  input logic               ea_we,
  input logic               ba_we,
  input logic [XLEN-1:0]    link_pc,
  input logic               gie,
  input logic               eie,
  input logic               bie
);
  logic irq_live;
  logic other_req;
  assign irq_live  = |(irq_pending & irq_mask);
  assign other_req = req_bkpt | req_ibus | req_wpt | req_dbus | req_div0 | req_scall;

  assert_one_link_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ea_we && ba_we));

  assert_link_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_we || ba_we) |-> (link_pc == cur_pc && redirect));

  assert_eie_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ea_we |=> (eie == $past(gie) && !gie && $stable(bie)));

  assert_bie_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ba_we |=> (bie == $past(gie) && !gie && $stable(eie)));

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!other_req && (!gie || !irq_live)) |-> !exc_taken);

  assert_bkpt_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_bkpt |-> (exc_taken && exc_cause == 3'd1));

  assert_eret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !exc_taken) |=> (gie == $past(eie)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cur_pc      (cur_pc),
  .irq_pending (irq_pending),
  .irq_mask    (irq_mask),
  .req_bkpt    (req_bkpt),
  .req_ibus    (req_ibus),
  .req_wpt     (req_wpt),
  .req_dbus    (req_dbus),
  .req_div0    (req_div0),
  .req_scall   (req_scall),
  .eret        (eret),
  .redirect    (redirect),
  .exc_taken   (exc_taken),
  .exc_cause   (exc_cause),
  .ea_we       (ea_we),
  .ba_we       (ba_we),
  .link_pc     (link_pc),
  .gie         (gie),
  .eie         (eie),
  .bie         (bie)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cur_pc;
  logic        req_bkpt, req_ibus, req_wpt, req_dbus, req_div0, req_scall;
  logic [31:0] irq_pending, irq_mask;
  logic [31:0] exc_base, dbg_base;
  logic        remap_en, eret, bret, ie_wr;
  logic [31:0] ea_val, ba_val;
  logic [2:0]  ie_wdata;
  logic        redirect, exc_taken, ea_we, ba_we, gie, eie, bie;
  logic [31:0] redirect_pc, link_pc;
  logic [2:0]  exc_cause;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  exc_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc),
    .req_bkpt(req_bkpt), .req_ibus(req_ibus), .req_wpt(req_wpt),
    .req_dbus(req_dbus), .req_div0(req_div0), .req_scall(req_scall),
    .irq_pending(irq_pending), .irq_mask(irq_mask),
    .exc_base(exc_base), .dbg_base(dbg_base), .remap_en(remap_en),
    .eret(eret), .bret(bret), .ea_val(ea_val), .ba_val(ba_val),
    .ie_wr(ie_wr), .ie_wdata(ie_wdata),
    .redirect(redirect), .redirect_pc(redirect_pc),
    .exc_taken(exc_taken), .exc_cause(exc_cause),
    .ea_we(ea_we), .ba_we(ba_we), .link_pc(link_pc),
    .gie(gie), .eie(eie), .bie(bie)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    {req_bkpt, req_ibus, req_wpt, req_dbus, req_div0, req_scall} = '0;
    irq_pending = '0; irq_mask = '0;
    eret = 0; bret = 0; ie_wr = 0; ie_wdata = '0;
  endtask

  task automatic load_ie(input logic [2:0] s);
    @(negedge clk);
    idle();
    ie_wr = 1; ie_wdata = s;
    #2 chk(!redirect, "R11 no redirect on write", {31'b0, redirect}, 0);
    @(posedge clk); #2;
    chk({bie, eie, gie} == s, "R11 enable write", {29'b0, bie, eie, gie}, {29'b0, s});
    @(negedge clk);
    idle();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle();
    cur_pc = 32'h0000_1000; exc_base = 32'h1000_0000; dbg_base = 32'hFFFF_FF80;
    remap_en = 0; ea_val = 32'h0000_4444; ba_val = 32'h0000_8888;
    repeat (3) @(posedge clk);
    #2 chk({bie, eie, gie} == 3'b000, "R10 reset enables", {29'b0, bie, eie, gie}, 0);
    chk(!redirect, "R10 no redirect", {31'b0, redirect}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(!redirect && !exc_taken, "R10 idle after reset", {31'b0, redirect}, 0);

    // Main sweep: all request combinations, irq modes, enable states, remap
    for (int st = 0; st < 8; st++) begin
      for (int rm = 0; rm < 2; rm++) begin
        for (int irqm = 0; irqm < 3; irqm++) begin
          for (int rq = 0; rq < 64; rq++) begin
            logic [2:0]  s;
            logic [7:0]  rv;
            int          ec;
            logic [31:0] base, expv;
            logic        dbg;
            s = 3'(st);
            load_ie(s);
            remap_en = rm[0];
            cur_pc   = 32'h0100_0000 + 32'(rq * 4 + irqm * 512 + st * 4096);
            exc_base = 32'h2000_0000 + 32'(st * 256);
            dbg_base = 32'hFFFF_FF00 + 32'(rq);
            {req_scall, req_div0, req_dbus, req_wpt, req_ibus, req_bkpt} = 6'(rq);
            irq_pending = (irqm == 0) ? 32'h0 : 32'h0000_0100 << st;
            irq_mask    = (irqm == 2) ? 32'hFFFF_FFFF : ~irq_pending;
            rv = {req_scall, (irqm == 2) & s[0], req_div0, req_dbus,
                  req_wpt, req_ibus, req_bkpt, 1'b0};
            ec = -1;
            for (int b = 7; b >= 1; b--) if (rv[b]) ec = b;
            #2;
            if (ec < 0) begin
              chk(!exc_taken && !redirect, "R7 no cause accepted",
                  {31'b0, exc_taken}, 0);
            end else begin
              dbg  = (ec == 1) || (ec == 3);
              base = rm[0] ? dbg_base : exc_base;
              expv = base + 32'(ec * 32);
              chk(exc_taken && exc_cause == 3'(ec), "R1 priority cause",
                  {29'b0, exc_cause}, 32'(ec));
              chk(redirect_pc == expv, rm[0] ? "R6 remap base vector" : "R5 vector address",
                  redirect_pc, expv);
              chk(redirect && link_pc == cur_pc && ea_we == !dbg && ba_we == dbg,
                  dbg ? "R4 debug link write" : "R2 exception link write",
                  {ea_we, ba_we, redirect}, {!dbg, dbg, 1'b1});
              @(posedge clk); #2;
              if (dbg)
                chk({bie, eie, gie} == {s[0], s[1], 1'b0}, "R4 debug enable save",
                    {29'b0, bie, eie, gie}, {29'b0, s[0], s[1], 1'b0});
              else
                chk({bie, eie, gie} == {s[2], s[0], 1'b0}, "R3 exception enable save",
                    {29'b0, bie, eie, gie}, {29'b0, s[2], s[0], 1'b0});
            end
            @(negedge clk);
            idle();
          end
        end
      end
    end

    // Return and write priority sweep
    for (int st = 0; st < 8; st++) begin
      for (int cmb = 0; cmb < 16; cmb++) begin
        logic [2:0]  s, exps;
        logic [31:0] expv;
        logic        expr;
        s = 3'(st);
        load_ie(s);
        remap_en = 0; exc_base = 32'h3000_0000;
        ea_val = 32'hE000_0000 + 32'(cmb); ba_val = 32'hB000_0000 + 32'(st);
        req_scall = cmb[0]; eret = cmb[1]; bret = cmb[2];
        ie_wr = cmb[3]; ie_wdata = ~s;
        if (cmb[0]) begin
          exps = {s[2], s[0], 1'b0}; expv = 32'h3000_0000 + 32'd224; expr = 1;
        end else if (cmb[1]) begin
          exps = {s[2], s[1], s[1]}; expv = ea_val; expr = 1;
        end else if (cmb[2]) begin
          exps = {s[2], s[1], s[2]}; expv = ba_val; expr = 1;
        end else if (cmb[3]) begin
          exps = ~s; expv = 32'h0; expr = 0;
        end else begin
          exps = s; expv = 32'h0; expr = 0;
        end
        #2;
        chk(redirect == expr, "R9 redirect presence", {31'b0, redirect}, {31'b0, expr});
        if (expr)
          chk(redirect_pc == expv, cmb[0] ? "R9 cause beats return" : "R8 return target",
              redirect_pc, expv);
        @(posedge clk); #2;
        chk({bie, eie, gie} == exps,
            (cmb[0] || (cmb[1] && cmb[2]) || cmb[3]) ? "R9 priority enables" : "R8 return enables",
            {29'b0, bie, eie, gie}, {29'b0, exps});
        @(negedge clk);
        idle();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule